// File: doc/BRIEF.md
# Link Bring-Up Supervisor with Stuck Speed-Change Recovery

This block supervises a serial link from the moment software asks for bring-up until the link is trained or declared dead. A `start` pulse makes it write the generation-1 code into the maximum-speed field of the link capability word. One cycle later it enables the training state machine. It then checks the link status once per poll interval. The link counts as up when the link-up flag is set and the in-training flag is clear. When that happens the block ends at once with a pass status. If the link never comes up within the allowed number of polls, the block ends with a fail status.

While the link is down, every poll reads the receiver-valid register of the PHY through an indirect request/acknowledge port. A specific failure can occur during a speed change: the receiver is not valid while training is stuck in the receiver-lock recovery state (state code 0x0D). When the block sees this, it forces two receive-override bits on by read-modify-write, holds them for a fixed time, and then clears them again by read-modify-write. An error reported by the PHY port abandons the current recovery attempt. Polling then goes on, and the error is not counted as a link failure. All delays come from one cycles-per-microsecond prescaler.

Top module: `lnk_train_supervisor`

## Requirements
- R1: A `start` accepted while idle makes `capWr` pulse for exactly one cycle, with `capSpeed` = 4'd1 (generation 1 only).
- R2: `ltssmEn` is low during the `capWr` cycle and goes high in the next cycle. It stays high after the run ends, until the next accepted `start`. No PHY request is issued while `ltssmEn` is low.
- R3: The link counts as up when `linkUpIn` = 1 and `inTrainingIn` = 0 at a check. The run then ends with `done` and `pass` = 1, and that poll makes no PHY access. If the link is up at the first check, `done` follows the `capWr` cycle by two cycles.
- R4: At each check with the link down, the block reads PHY address RXV_ADDR (0x100D), and bit 0 of the returned data is receiver-valid. Between the acknowledge that ends a poll and the next receiver-valid request there are POLL_US×CLK_PER_US + 2 cycles.
- R5: If receiver-valid = 0 and `ltssmStateIn` = 0x0D, the block reads OVR_ADDR (0x1005) and writes back the value read with bits 5 and 3 set (mask 0x0028). All other bits keep their values.
- R6: After the setting write is acknowledged, the block waits HOLD_US×CLK_PER_US cycles. It then reads OVR_ADDR again and writes the value read with bits 5 and 3 cleared. The gap from the setting-write acknowledge to the next read request is HOLD_US×CLK_PER_US + 1 cycles.
- R7: If receiver-valid = 1, or `ltssmStateIn` is not 0x0D, the poll makes no access to OVR_ADDR.
- R8: `phyErr` together with `phyAck` during a recovery step abandons that recovery. The next PHY access is the receiver-valid read of the following poll, and the poll count is not shortened.
- R9: After MAX_POLLS checks without link-up, the run ends with `done` and `pass` = 0.
- R10: `done` is a one-cycle pulse. `start` is ignored while a run is in progress. After `done`, no PHY request is issued until the next `start`.
- R11: Once `phyReq` is raised, it stays high with `phyAddr`, `phyWe` and `phyWrData` unchanged until the cycle in which `phyAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (taken only while idle) |
| capWr | output | 1 | Strobe: write `capSpeed` into the capability speed field |
| capSpeed | output | 4 | Maximum-speed code to write (always 1) |
| ltssmEn | output | 1 | Enable for the training state machine |
| ltssmStateIn | input | 6 | Current training state (low 6 bits of debug status word 0) |
| linkUpIn | input | 1 | Link-up flag (bit 4 of debug status word 1) |
| inTrainingIn | input | 1 | In-training flag (bit 29 of debug status word 1) |
| phyReq | output | 1 | Indirect PHY access request |
| phyWe | output | 1 | 1 = write, 0 = read |
| phyAddr | output | PHY_AW | PHY register address |
| phyWrData | output | PHY_DW | PHY write data |
| phyAck | input | 1 | One-cycle acknowledge of the current request |
| phyErr | input | 1 | Error, valid with `phyAck` |
| phyRdData | input | PHY_DW | Read data, valid with `phyAck` |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, valid from `done` until the next start |

## Verification
The assertions assume that the PHY port answers each request with exactly one `phyAck` pulse, and never raises `phyAck` without a pending request. They also assume that the status inputs change only away from the clock edge. The bench's PHY responder acknowledges only while `phyReq` is high, after a random latency of zero to two cycles. It drops the acknowledge in the cycle after. All status inputs change on falling edges. Random runs vary receiver-valid, training state, the stored override value and the poll at which the link appears. Directed runs cover an immediate link, an in-training link, a continuous stuck condition, an injected PHY error, and a run restarted while it is busy.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int          SPEED_W    = 4;
  localparam logic [3:0]  GEN1_CODE  = 4'd1;
  localparam int          STATE_W    = 6;
  localparam logic [5:0]  STUCK_CODE = 6'h0D;

  typedef enum logic [3:0] {
    S_IDLE, S_CAPW, S_CHECK, S_RXV, S_ORD1, S_OWR1, S_HOLD, S_ORD2, S_OWR2, S_WAIT
  } lnkState_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_RD_RXV, OP_RD_OVR, OP_WR_SET, OP_WR_CLR
  } phyOp_t;

  typedef struct packed {
    logic   tmrLoadPoll;
    logic   tmrLoadHold;
    logic   tmrRun;
    logic   pollClr;
    logic   pollInc;
    logic   ovrCapture;
    phyOp_t phyOp;
  } lnkStrb_t;

endpackage

// File: rtl/lnk_datapath.sv
module lnk_datapath
  import lnk_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int POLL_US    = 10,
  parameter int HOLD_US    = 3000,
  parameter int MAX_POLLS  = 4000,
  parameter int PHY_AW     = 16,
  parameter int PHY_DW     = 16,
  parameter int RXV_BIT    = 0,
  parameter logic [PHY_AW-1:0] RXV_ADDR = 16'h100D,
  parameter logic [PHY_AW-1:0] OVR_ADDR = 16'h1005,
  parameter logic [PHY_DW-1:0] OVR_MASK = 16'h0028
) (
  input  logic              clk,
  input  logic              rstN,
  input  lnkStrb_t          strb,
  input  logic [STATE_W-1:0] ltssmStateIn,
  input  logic              linkUpIn,
  input  logic              inTrainingIn,
  input  logic [PHY_DW-1:0] phyRdData,
  output logic              linkUp,
  output logic              stuckState,
  output logic              rxValid,
  output logic              tmrDone,
  output logic              pollLast,
  output logic              phyReq,
  output logic              phyWe,
  output logic [PHY_AW-1:0] phyAddr,
  output logic [PHY_DW-1:0] phyWrData
);

  localparam int POLL_CYC = CLK_PER_US * POLL_US;
  localparam int HOLD_CYC = CLK_PER_US * HOLD_US;
  localparam int TMR_MAX  = (POLL_CYC > HOLD_CYC) ? POLL_CYC : HOLD_CYC;
  localparam int TW       = $clog2(TMR_MAX + 1);
  localparam int PW       = $clog2(MAX_POLLS + 1);

  logic [TW-1:0]     tmr;
  logic [PW-1:0]     pollCnt;
  logic [PHY_DW-1:0] ovrVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr     <= '0;
      pollCnt <= '0;
      ovrVal  <= '0;
    end else begin
      if (strb.tmrLoadPoll)                 tmr <= TW'(POLL_CYC - 1);
      else if (strb.tmrLoadHold)            tmr <= TW'(HOLD_CYC - 1);
      else if (strb.tmrRun && tmr != '0)    tmr <= tmr - 1'b1;

      if (strb.pollClr)      pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;

      if (strb.ovrCapture) ovrVal <= phyRdData;
    end
  end

  assign tmrDone    = (tmr == '0);
  assign pollLast   = (pollCnt == PW'(MAX_POLLS - 1));
  assign linkUp     = linkUpIn & ~inTrainingIn;
  assign stuckState = (ltssmStateIn == STUCK_CODE);
  assign rxValid    = phyRdData[RXV_BIT];

  always_comb begin
    phyReq    = 1'b1;
    phyWe     = 1'b0;
    phyAddr   = OVR_ADDR;
    phyWrData = ovrVal;
    unique case (strb.phyOp)
      OP_RD_RXV: phyAddr = RXV_ADDR;
      OP_RD_OVR: ;
      OP_WR_SET: begin phyWe = 1'b1; phyWrData = ovrVal | OVR_MASK;  end
      OP_WR_CLR: begin phyWe = 1'b1; phyWrData = ovrVal & ~OVR_MASK; end
      default:   phyReq = 1'b0;
    endcase
  end

endmodule

// File: rtl/lnk_control.sv
module lnk_control
  import lnk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     linkUp,
  input  logic     stuckState,
  input  logic     rxValid,
  input  logic     tmrDone,
  input  logic     pollLast,
  input  logic     phyAck,
  input  logic     phyErr,
  output lnkStrb_t strb,
  output logic     capWr,
  output logic     ltssmEn,
  output logic     done,
  output logic     pass
);

  lnkState_t state, nextState;
  logic      finish, finPass;

  always_comb begin
    nextState = state;
    strb      = '0;
    finish    = 1'b0;
    finPass   = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        nextState    = S_CAPW;
        strb.pollClr = 1'b1;
      end
      S_CAPW: nextState = S_CHECK;
      S_CHECK: begin
        if (linkUp) begin
          nextState = S_IDLE;
          finish    = 1'b1;
          finPass   = 1'b1;
        end else begin
          nextState = S_RXV;
        end
      end
      S_RXV: begin
        strb.phyOp = OP_RD_RXV;
        if (phyAck) begin
          if (phyErr || rxValid || !stuckState) begin
            nextState        = S_WAIT;
            strb.tmrLoadPoll = 1'b1;
          end else begin
            nextState = S_ORD1;
          end
        end
      end
      S_ORD1, S_ORD2: begin
        strb.phyOp = OP_RD_OVR;
        if (phyAck) begin
          if (phyErr) begin
            nextState        = S_WAIT;
            strb.tmrLoadPoll = 1'b1;
          end else begin
            strb.ovrCapture = 1'b1;
            nextState       = (state == S_ORD1) ? S_OWR1 : S_OWR2;
          end
        end
      end
      S_OWR1: begin
        strb.phyOp = OP_WR_SET;
        if (phyAck) begin
          if (phyErr) begin
            nextState        = S_WAIT;
            strb.tmrLoadPoll = 1'b1;
          end else begin
            nextState        = S_HOLD;
            strb.tmrLoadHold = 1'b1;
          end
        end
      end
      S_HOLD: begin
        strb.tmrRun = 1'b1;
        if (tmrDone) nextState = S_ORD2;
      end
      S_OWR2: begin
        strb.phyOp = OP_WR_CLR;
        if (phyAck) begin
          nextState        = S_WAIT;
          strb.tmrLoadPoll = 1'b1;
        end
      end
      S_WAIT: begin
        strb.tmrRun = 1'b1;
        if (tmrDone) begin
          if (pollLast) begin
            nextState = S_IDLE;
            finish    = 1'b1;
          end else begin
            nextState    = S_CHECK;
            strb.pollInc = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      ltssmEn <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finish;
      if (finish) pass <= finPass;
      if (state == S_IDLE && start) begin
        pass    <= 1'b0;
        ltssmEn <= 1'b0;
      end
      if (state == S_CAPW) ltssmEn <= 1'b1;
    end
  end

  assign capWr = (state == S_CAPW);

endmodule

// File: rtl/lnk_train_supervisor.sv
module lnk_train_supervisor
  import lnk_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int POLL_US    = 10,
  parameter int HOLD_US    = 3000,
  parameter int MAX_POLLS  = 4000,
  parameter int PHY_AW     = 16,
  parameter int PHY_DW     = 16,
  parameter logic [PHY_AW-1:0] RXV_ADDR = 16'h100D,
  parameter logic [PHY_AW-1:0] OVR_ADDR = 16'h1005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              capWr,
  output logic [3:0]        capSpeed,
  output logic              ltssmEn,
  input  logic [5:0]        ltssmStateIn,
  input  logic              linkUpIn,
  input  logic              inTrainingIn,
  output logic              phyReq,
  output logic              phyWe,
  output logic [PHY_AW-1:0] phyAddr,
  output logic [PHY_DW-1:0] phyWrData,
  input  logic              phyAck,
  input  logic              phyErr,
  input  logic [PHY_DW-1:0] phyRdData,
  output logic              done,
  output logic              pass
);

  lnkStrb_t strb;
  logic linkUp, stuckState, rxValid, tmrDone, pollLast;

  assign capSpeed = GEN1_CODE;

  lnk_control uCtl (
    .clk, .rstN, .start, .linkUp, .stuckState, .rxValid, .tmrDone, .pollLast,
    .phyAck, .phyErr, .strb, .capWr, .ltssmEn, .done, .pass
  );

  lnk_datapath #(
    .CLK_PER_US(CLK_PER_US), .POLL_US(POLL_US), .HOLD_US(HOLD_US),
    .MAX_POLLS(MAX_POLLS), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW),
    .RXV_ADDR(RXV_ADDR), .OVR_ADDR(OVR_ADDR)
  ) uDp (
    .clk, .rstN, .strb, .ltssmStateIn, .linkUpIn, .inTrainingIn, .phyRdData,
    .linkUp, .stuckState, .rxValid, .tmrDone, .pollLast,
    .phyReq, .phyWe, .phyAddr, .phyWrData
  );

endmodule

// File: rtl/lnk_checks.sv
module lnk_checks #(
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              capWr,
  input logic              ltssmEn,
  input logic              linkUpIn,
  input logic              inTrainingIn,
  input logic              phyReq,
  input logic              phyWe,
  input logic [PHY_AW-1:0] phyAddr,
  input logic [PHY_DW-1:0] phyWrData,
  input logic              phyAck,
  input logic              done,
  input logic              pass
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    phyReq && !phyAck |=> phyReq && $stable(phyAddr) && $stable(phyWe) && $stable(phyWrData)); // R11

  AST_EN_AFTER_CAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ltssmEn) |-> $past(capWr)); // R2

  AST_NO_PHY_UNTRAINED: assert property (@(posedge clk) disable iff (!rstN)
    !ltssmEn |-> !phyReq); // R2

  AST_CAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    capWr |=> !capWr); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_PASS_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rstN)
    done && pass |-> $past(linkUpIn && !inTrainingIn)); // R3

endmodule

bind lnk_train_supervisor lnk_checks #(.PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) uChk (.*);

// File: tb/sim_lnk_train_supervisor.sv
`timescale 1ns/1ps
module sim_lnk_train_supervisor;

  localparam int CPU = 2, PUS = 3, HUS = 5, MP = 5;
  localparam int POLL_CYC = CPU * PUS;
  localparam int HOLD_CYC = CPU * HUS;
  localparam logic [15:0] RXV = 16'h100D, OVR = 16'h1005, MASK = 16'h0028;

  logic clk = 0, rstN = 0, start = 0;
  logic capWr, ltssmEn, phyReq, phyWe, done, pass;
  logic [3:0] capSpeed;
  logic [5:0] ltssmStateIn = '0;
  logic linkUpIn = 0, inTrainingIn = 0;
  logic [15:0] phyAddr, phyWrData, phyRdData = '0;
  logic phyAck = 0, phyErr = 0;

  always #4 clk = ~clk;

  lnk_train_supervisor #(.CLK_PER_US(CPU), .POLL_US(PUS), .HOLD_US(HUS), .MAX_POLLS(MP)) u0 (
    .clk, .rstN, .start, .capWr, .capSpeed, .ltssmEn, .ltssmStateIn, .linkUpIn,
    .inTrainingIn, .phyReq, .phyWe, .phyAddr, .phyWrData, .phyAck, .phyErr,
    .phyRdData, .done, .pass);

  int nChk = 0, nBad = 0, cyc = 0;
  int txN = 0, rxvReads = 0, upAfter = -1, errAt = -1, hsBad = 0, capCount = 0, lat = 0;
  bit inFlight = 0, rxvModel = 0;
  logic [15:0] ovrModel = '0, reqAddr = '0;
  logic [15:0] txAddr [0:63];
  logic [15:0] txData [0:63];
  bit          txWe   [0:63];
  int          txReq  [0:63];
  int          txAck  [0:63];

  always @(posedge clk) cyc <= cyc + 1;

  // PHY responder and capability-strobe monitor
  always @(negedge clk) begin
    if (capWr) capCount = capCount + 1;
    if (phyAck) begin
      phyAck = 0;
      phyErr = 0;
    end else if (phyReq) begin
      if (!inFlight) begin
        inFlight = 1; reqAddr = phyAddr; lat = int'($urandom % 3);
        if (txN < 64) txReq[txN] = cyc;
      end
      if (lat == 0) begin
        phyAck = 1;
        phyErr = (txN == errAt);
        if (phyAddr != reqAddr) hsBad = hsBad + 1;
        if (txN < 64) begin
          txAddr[txN] = phyAddr; txWe[txN] = phyWe; txData[txN] = phyWrData; txAck[txN] = cyc;
        end
        if (!phyWe) begin
          if (phyAddr == RXV) begin
            phyRdData = {15'($urandom), rxvModel};
            rxvReads = rxvReads + 1;
            if (rxvReads == upAfter) linkUpIn = 1;
          end else phyRdData = ovrModel;
        end else if (!phyErr && phyAddr == OVR) ovrModel = phyWrData;
        txN = txN + 1;
        inFlight = 0;
      end else lat = lat - 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk = nChk + 1;
    if (!ok) begin
      nBad = nBad + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int perPoll(input bit rxv, input bit stuck);
    return (rxv || !stuck) ? 1 : 5;
  endfunction

  // Runs one bring-up; returns negedges from the capWr cycle to done and the pass value
  task automatic runCase(input bit extraStart, output int lag, output bit res);
    txN = 0; rxvReads = 0; capCount = 0; lag = 0;
    if (upAfter == 0) linkUpIn = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(capWr == 1 && capSpeed == 4'd1, "R1", "capWr/capSpeed", {capWr, capSpeed}, 5'h11);
    chk(ltssmEn == 0, "R2", "ltssmEn during capWr", ltssmEn, 0);
    @(negedge clk); lag = 1;
    chk(ltssmEn == 1, "R2", "ltssmEn after capWr", ltssmEn, 1);
    while (!done) begin
      if (extraStart && lag == 4) start = 1; else start = 0;
      @(negedge clk); lag = lag + 1;
      if (lag > 4000) begin
        chk(0, "WATCHDOG", "run did not finish", lag, 0);
        summary();
      end
    end
    start = 0;
    res = pass;
    @(negedge clk);
    chk(done == 0, "R10", "done pulse width", done, 0);
    chk(ltssmEn == 1, "R2", "ltssmEn held after run", ltssmEn, 1);
    repeat (8) begin
      @(negedge clk);
      if (phyReq) chk(0, "R10", "PHY request after done", 1, 0);
    end
    chk(capCount == 1, "R10", "capability strobes per run", capCount, 1);
    linkUpIn = 0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    chk(0, "WATCHDOG", "global timeout", cyc, 0);
    summary();
  end

  initial begin
    int lag; bit res;
    void'($urandom(32'd1717));
    repeat (3) @(negedge clk);
    chk(done == 0 && ltssmEn == 0 && phyReq == 0 && capWr == 0 && pass == 0,
        "R2", "reset state", {done, ltssmEn, phyReq, capWr, pass}, 0);
    rstN = 1;
    @(negedge clk);

    // Link already up: R3
    upAfter = 0; errAt = -1; rxvModel = 1; ltssmStateIn = 6'h0D;
    runCase(0, lag, res);
    chk(res == 1, "R3", "pass on immediate link", res, 1);
    chk(lag == 2, "R3", "cycles capWr->done", lag, 2);
    chk(txN == 0, "R3", "PHY accesses on link-up poll", txN, 0);

    // Link flag with in-training set, restart attempt while busy: R3 R9 R4 R10
    upAfter = -1; inTrainingIn = 1; rxvModel = 1;
    linkUpIn = 1;
    runCase(1, lag, res);
    inTrainingIn = 0;
    chk(res == 0, "R9", "fail after all polls", res, 0);
    chk(txN == MP, "R9", "receiver-valid reads", txN, MP);
    chk(txAddr[0] == RXV && txWe[0] == 0, "R4", "poll reads 0x100D", txAddr[0], RXV);
    chk(txReq[1] - txAck[0] == POLL_CYC + 2, "R4", "poll spacing", txReq[1] - txAck[0], POLL_CYC + 2);

    // Continuous stuck speed change: R5 R6
    upAfter = -1; rxvModel = 0; ltssmStateIn = 6'h0D; ovrModel = 16'h8413;
    runCase(0, lag, res);
    chk(txN == 5 * MP, "R5", "accesses with recovery each poll", txN, 5 * MP);
    chk(txAddr[1] == OVR && txWe[1] == 0, "R5", "override read", txAddr[1], OVR);
    chk(txAddr[2] == OVR && txWe[2] == 1 && txData[2] == 16'h843B, "R5", "set write data", txData[2], 16'h843B);
    chk(txReq[3] - txAck[2] == HOLD_CYC + 1, "R6", "hold time", txReq[3] - txAck[2], HOLD_CYC + 1);
    chk(txWe[4] == 1 && txData[4] == 16'h8413, "R6", "clear write data", txData[4], 16'h8413);
    chk(res == 0, "R9", "stuck link fails", res, 0);

    // PHY error aborts recovery: R8
    errAt = 1; ovrModel = 16'h0FFF;
    runCase(0, lag, res);
    errAt = -1;
    chk(txAddr[2] == RXV, "R8", "next access after error", txAddr[2], RXV);
    chk(txN == 2 + 5 * (MP - 1), "R8", "accesses with aborted recovery", txN, 2 + 5 * (MP - 1));
    chk(res == 0, "R8", "result after error run", res, 0);

    // Receiver invalid but not in recovery lock: R7
    ltssmStateIn = 6'h0C;
    runCase(0, lag, res);
    chk(txN == MP, "R7", "no override access", txN, MP);

    // Random runs: R4 R5 R7 R3 R9
    for (int i = 0; i < 10; i++) begin
      bit stuck; int expN; bit expPass; logic [15:0] init;
      rxvModel = 1'($urandom);
      stuck = 1'($urandom);
      ltssmStateIn = stuck ? 6'h0D : 6'($urandom % 13);
      upAfter = int'($urandom % (MP + 2));
      init = 16'($urandom);
      ovrModel = init;
      expPass = (upAfter <= MP - 1);
      expN = (expPass ? upAfter : MP) * perPoll(rxvModel, stuck);
      runCase(0, lag, res);
      chk(res == expPass, "R3", "random run result", res, expPass);
      chk(txN == expN, "R7", "random run access count", txN, expN);
      if (perPoll(rxvModel, stuck) == 5 && txN >= 5) begin
        chk(txData[2] == (init | MASK), "R5", "random set write", txData[2], init | MASK);
        chk(txData[4] == (init & ~MASK), "R6", "random clear write", txData[4], init & ~MASK);
      end
    end

    chk(hsBad == 0, "R11", "address stable until ack", hsBad, 0);
    summary();
  end

endmodule